// File: doc/BRIEF.md
# Dual-Bank Interrupt Vector Table with Atomic Swap

This block holds the interrupt vector table in two equally sized physical banks. The banks are reached through two fixed address windows. The interrupt dispatch path always reads the bank that sits behind the active window. Software rewrites the other bank through the shadow window while interrupts keep being served. When the new table is ready, a keyed swap command exchanges the two banks between the windows within one clock edge. The former active table then becomes the next shadow, so successive firmware updates alternate between the banks.

The bus port works in 16-bit address units. Each 32-bit vector takes two consecutive addresses, and accesses can be one half or the whole vector. Vector fetches are indexed directly by interrupt number and return one cycle later. A one-bit status output reports which physical bank is currently active.

Top module: `vecswap_table`

## Requirements
- R1: After reset, activeBank is 0, fetchValid is 0 and busRvalid is 0.
- R2: A fetch request with index i sets fetchValid in the next cycle, with fetchVec equal to entry i of the active bank. An index of 192 or more returns zero.
- R3: A write with busWide=1 to shadow window address 0x01000900+2*i (i < 192) stores busWdata as entry i of the shadow bank. A read with busWide=1 at that address returns the entry on busRdata in the cycle after the request, with busRvalid set.
- R4: With busWide=0, an even address selects the low 16 bits of an entry and an odd address selects the high 16 bits. A write takes the half from busWdata[15:0] and leaves the other half unchanged. A read returns the half zero-extended in busRdata[15:0].
- R5: The active window 0x0D00+2*i reads entry i of the active bank. Writes to the active window are ignored.
- R6: A swapReq with swapKey equal to 0xA5 inverts activeBank in the next cycle. From then on the two windows show each other's former contents.
- R7: A swapReq with any other key value leaves activeBank and both windows' contents unchanged.
- R8: A fetch issued in the same cycle as a swap returns the entry of the pre-swap active bank. A fetch in the following cycle uses the new mapping.
- R9: A shadow write issued in the same cycle as a swap goes to the bank that was the shadow before the swap, which is the bank that becomes active.
- R10: Reads of window entries at index 192 or above, and reads outside both windows, return zero. Writes there change no entry.
- R11: Successive keyed swaps alternate activeBank and the active table, in ping-pong order.
- R12: A shadow write in the same cycle as a fetch of the same index does not change the value that the fetch returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Bus access request, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| busAddr | input | 32 | Address in 16-bit units |
| busWdata | input | 32 | Write data; 16-bit writes use the low half |
| busRdata | output | 32 | Read data, one cycle after the request |
| busRvalid | output | 1 | Read data valid |
| fetchReq | input | 1 | Vector fetch request |
| fetchIdx | input | 8 | Interrupt number to fetch |
| fetchVec | output | 32 | Fetched vector, one cycle after the request |
| fetchValid | output | 1 | Fetched vector valid |
| swapReq | input | 1 | Swap command |
| swapKey | input | 8 | Key that must match for the swap to be taken |
| activeBank | output | 1 | Physical bank currently behind the active window |

## Verification
The properties assume that every control input carries a known 0 or 1 from the first edge after reset. They also assume that each bus request lasts one cycle and that the two windows do not overlap, so any address falls in at most one window. The stimulus drives every input to a defined value before reset is released. It changes inputs only at the falling clock edge and clears each request one cycle after raising it. Addresses that fall outside both windows are applied only on reads.

// File: rtl/vecswap_pkg.sv
package vecswap_pkg;

  // Strobes from the address/swap control to the storage datapath
  typedef struct packed {
    logic wrLo;       // write low half of the addressed entry
    logic wrHi;       // write high half of the addressed entry
    logic wrBank;     // physical bank the write goes to
    logic rdEn;       // a bus read is requested this cycle
    logic rdHit;      // the read lands on a valid entry
    logic rdBank;     // physical bank the read comes from
    logic rdHalfHi;   // 16-bit read selects the high half
    logic wide;       // 32-bit access
    logic fetchBank;  // physical bank serving vector fetches
  } vecStrobe_t;

endpackage

// File: rtl/vecswap_ctrl.sv
module vecswap_ctrl
  import vecswap_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DEPTH        = 192,
  parameter int WINDOW_WORDS = 512,
  parameter logic [ADDR_W-1:0] ACTIVE_BASE = 32'h0000_0D00,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h0100_0900,
  parameter int KEY_W        = 8,
  parameter logic [KEY_W-1:0] SWAP_KEY = 8'hA5,
  localparam int OFF_W = $clog2(WINDOW_WORDS),
  localparam int IDX_W = OFF_W - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              swapReq,
  input  logic [KEY_W-1:0]  swapKey,
  output vecStrobe_t        strobe,
  output logic [IDX_W-1:0]  busIdx,
  output logic              activeBank
);

  logic              bankSel;
  logic              swapTake;
  logic [ADDR_W-1:0] offActive;
  logic [ADDR_W-1:0] offShadow;
  logic              inActive;
  logic              inShadow;
  logic [IDX_W-1:0]  entryActive;
  logic [IDX_W-1:0]  entryShadow;
  logic              hitActive;
  logic              hitShadow;
  logic              halfHi;

  assign swapTake = swapReq && (swapKey == SWAP_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) bankSel <= 1'b0;
    else if (swapTake) bankSel <= ~bankSel;
  end

  assign offActive = busAddr - ACTIVE_BASE;
  assign offShadow = busAddr - SHADOW_BASE;
  assign inActive  = (busAddr >= ACTIVE_BASE) && (offActive < ADDR_W'(WINDOW_WORDS));
  assign inShadow  = (busAddr >= SHADOW_BASE) && (offShadow < ADDR_W'(WINDOW_WORDS));

  assign entryActive = offActive[OFF_W-1:1];
  assign entryShadow = offShadow[OFF_W-1:1];
  assign hitActive   = inActive && (entryActive < IDX_W'(DEPTH));
  assign hitShadow   = inShadow && (entryShadow < IDX_W'(DEPTH));

  assign busIdx = inActive ? entryActive : entryShadow;
  assign halfHi = inActive ? offActive[0] : offShadow[0];

  always_comb begin
    strobe           = '0;
    strobe.wide      = busWide;
    strobe.wrBank    = ~bankSel;
    strobe.wrLo      = busReq && busWrite && hitShadow && (busWide || !halfHi);
    strobe.wrHi      = busReq && busWrite && hitShadow && (busWide || halfHi);
    strobe.rdEn      = busReq && !busWrite;
    strobe.rdHit     = hitActive || hitShadow;
    strobe.rdBank    = inActive ? bankSel : ~bankSel;
    strobe.rdHalfHi  = halfHi;
    strobe.fetchBank = bankSel;
  end

  assign activeBank = bankSel;

endmodule

// File: rtl/vecswap_datapath.sv
module vecswap_datapath
  import vecswap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 192,
  parameter int IDX_W  = 8,
  localparam int HALF_W = DATA_W / 2,
  localparam int BANKS  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  vecStrobe_t        strobe,
  input  logic [IDX_W-1:0]  busIdx,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              fetchReq,
  input  logic [IDX_W-1:0]  fetchIdx,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  output logic [DATA_W-1:0] fetchVec,
  output logic              fetchValid
);

  logic [DATA_W-1:0] bankBusWord   [BANKS];
  logic [DATA_W-1:0] bankFetchWord [BANKS];
  logic [HALF_W-1:0] hiWrData;
  logic              fetchInRange;
  logic [DATA_W-1:0] rdWord;
  logic [DATA_W-1:0] rdNext;

  assign hiWrData     = strobe.wide ? busWdata[DATA_W-1:HALF_W] : busWdata[HALF_W-1:0];
  assign fetchInRange = fetchIdx < IDX_W'(DEPTH);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    logic              selW;

    assign selW = (strobe.wrBank == 1'(b));

    always_ff @(posedge clk) begin
      if (selW && strobe.wrLo) mem[busIdx][HALF_W-1:0]      <= busWdata[HALF_W-1:0];
      if (selW && strobe.wrHi) mem[busIdx][DATA_W-1:HALF_W] <= hiWrData;
    end

    assign bankBusWord[b]   = mem[busIdx];
    assign bankFetchWord[b] = fetchInRange ? mem[fetchIdx] : '0;
  end

  assign rdWord = bankBusWord[strobe.rdBank];

  always_comb begin
    if (!strobe.rdHit)    rdNext = '0;
    else if (strobe.wide) rdNext = rdWord;
    else if (strobe.rdHalfHi) rdNext = {{HALF_W{1'b0}}, rdWord[DATA_W-1:HALF_W]};
    else                  rdNext = {{HALF_W{1'b0}}, rdWord[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busRdata   <= '0;
      busRvalid  <= 1'b0;
      fetchVec   <= '0;
      fetchValid <= 1'b0;
    end else begin
      busRvalid  <= strobe.rdEn;
      fetchValid <= fetchReq;
      if (strobe.rdEn) busRdata <= rdNext;
      if (fetchReq)    fetchVec <= bankFetchWord[strobe.fetchBank];
    end
  end

endmodule

// File: rtl/vecswap_table.sv
module vecswap_table
  import vecswap_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 192,
  parameter int WINDOW_WORDS = 512,
  parameter logic [ADDR_W-1:0] ACTIVE_BASE = 32'h0000_0D00,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h0100_0900,
  parameter int KEY_W        = 8,
  parameter logic [KEY_W-1:0] SWAP_KEY = 8'hA5,
  localparam int IDX_W = $clog2(WINDOW_WORDS) - 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busRvalid,
  input  logic              fetchReq,
  input  logic [IDX_W-1:0]  fetchIdx,
  output logic [DATA_W-1:0] fetchVec,
  output logic              fetchValid,
  input  logic              swapReq,
  input  logic [KEY_W-1:0]  swapKey,
  output logic              activeBank
);

  vecStrobe_t       strobe;
  logic [IDX_W-1:0] busIdx;

  vecswap_ctrl #(
    .ADDR_W(ADDR_W), .DEPTH(DEPTH), .WINDOW_WORDS(WINDOW_WORDS),
    .ACTIVE_BASE(ACTIVE_BASE), .SHADOW_BASE(SHADOW_BASE),
    .KEY_W(KEY_W), .SWAP_KEY(SWAP_KEY)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busReq(busReq), .busWrite(busWrite), .busWide(busWide), .busAddr(busAddr),
    .swapReq(swapReq), .swapKey(swapKey),
    .strobe(strobe), .busIdx(busIdx), .activeBank(activeBank)
  );

  vecswap_datapath #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_data (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .busIdx(busIdx), .busWdata(busWdata),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx),
    .busRdata(busRdata), .busRvalid(busRvalid),
    .fetchVec(fetchVec), .fetchValid(fetchValid)
  );

endmodule

// File: rtl/vecswap_chk.sv
module vecswap_chk #(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int DEPTH        = 192,
  parameter int WINDOW_WORDS = 512,
  parameter logic [ADDR_W-1:0] ACTIVE_BASE = 32'h0000_0D00,
  parameter logic [ADDR_W-1:0] SHADOW_BASE = 32'h0100_0900,
  parameter int KEY_W        = 8,
  parameter logic [KEY_W-1:0] SWAP_KEY = 8'hA5,
  localparam int IDX_W = $clog2(WINDOW_WORDS) - 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busWrite,
  input logic              busWide,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busRvalid,
  input logic              fetchReq,
  input logic [IDX_W-1:0]  fetchIdx,
  input logic [DATA_W-1:0] fetchVec,
  input logic              fetchValid,
  input logic              swapReq,
  input logic [KEY_W-1:0]  swapKey,
  input logic              activeBank
);

  logic keyedSwap;
  logic outsideWindows;

  assign keyedSwap = swapReq && (swapKey == SWAP_KEY);
  assign outsideWindows =
    !((busAddr >= ACTIVE_BASE) && (busAddr - ACTIVE_BASE < ADDR_W'(WINDOW_WORDS))) &&
    !((busAddr >= SHADOW_BASE) && (busAddr - SHADOW_BASE < ADDR_W'(WINDOW_WORDS)));

  // R2
  fetch_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    fetchReq |=> fetchValid);

  // R2
  fetch_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && fetchIdx >= IDX_W'(DEPTH)) |=> (fetchVec == '0));

  // R6
  swap_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyedSwap |=> (activeBank != $past(activeBank)));

  // R7
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !keyedSwap |=> $stable(activeBank));

  // R10
  outside_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite && outsideWindows) |=> (busRvalid && busRdata == '0));

  // R3
  read_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busWrite) |=> busRvalid);

endmodule

bind vecswap_table vecswap_chk chk (.*);

// File: tb/vecswap_table_test.sv
module vecswap_table_test;

  localparam logic [31:0] ACT_BASE = 32'h0000_0D00;
  localparam logic [31:0] SH_BASE  = 32'h0100_0900;
  localparam int          NVEC     = 192;
  localparam logic [7:0]  KEY      = 8'hA5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0, busWide = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata;
  logic        busRvalid;
  logic        fetchReq = 1'b0;
  logic [7:0]  fetchIdx = '0;
  logic [31:0] fetchVec;
  logic        fetchValid;
  logic        swapReq = 1'b0;
  logic [7:0]  swapKey = '0;
  logic        activeBank;

  int nChecks = 0;
  int nFail   = 0;

  logic [31:0] refMem [0:1][0:NVEC-1];
  logic        refSel = 1'b0;

  always #5 clk = ~clk;

  vecswap_table uut (
    .clk(clk), .rstN(rstN),
    .busReq(busReq), .busWrite(busWrite), .busWide(busWide),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busRvalid(busRvalid),
    .fetchReq(fetchReq), .fetchIdx(fetchIdx),
    .fetchVec(fetchVec), .fetchValid(fetchValid),
    .swapReq(swapReq), .swapKey(swapKey), .activeBank(activeBank)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] shAddr(int i);
    return SH_BASE + 32'(2 * i);
  endfunction

  function automatic logic [31:0] actAddr(int i);
    return ACT_BASE + 32'(2 * i);
  endfunction

  // Model of a bus write: only the shadow window is writable
  task automatic modelWrite(logic [31:0] a, logic [31:0] d, logic w);
    logic [31:0] off;
    int e;
    if (a >= SH_BASE && a - SH_BASE < 512) begin
      off = a - SH_BASE;
      e = int'(off >> 1);
      if (e < NVEC) begin
        if (w) refMem[refSel ^ 1'b1][e] = d;
        else if (off[0]) refMem[refSel ^ 1'b1][e][31:16] = d[15:0];
        else refMem[refSel ^ 1'b1][e][15:0] = d[15:0];
      end
    end
  endtask

  task automatic busWr(logic [31:0] a, logic [31:0] d, logic w);
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d; busWide = w;
    modelWrite(a, d, w);
    @(negedge clk);
    busReq = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(logic [31:0] a, logic w, output logic [31:0] d);
    @(negedge clk);
    busReq = 1'b1; busWrite = 1'b0; busAddr = a; busWide = w;
    @(negedge clk);
    d = busRdata;
    if (busRvalid !== 1'b1) check("R3 busRvalid", {31'b0, busRvalid}, 32'd1);
    busReq = 1'b0;
  endtask

  task automatic doFetch(int i, output logic [31:0] v);
    @(negedge clk);
    fetchReq = 1'b1; fetchIdx = 8'(i);
    @(negedge clk);
    v = fetchVec;
    if (fetchValid !== 1'b1) check("R2 fetchValid", {31'b0, fetchValid}, 32'd1);
    fetchReq = 1'b0;
  endtask

  task automatic doSwap(logic [7:0] k);
    @(negedge clk);
    swapReq = 1'b1; swapKey = k;
    if (k == KEY) refSel = refSel ^ 1'b1;
    @(negedge clk);
    swapReq = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 activeBank", {31'b0, activeBank}, 32'd0);
    check("R1 fetchValid", {31'b0, fetchValid}, 32'd0);
    check("R1 busRvalid",  {31'b0, busRvalid},  32'd0);
  endtask

  task automatic t_fillAndSwap;
    logic [31:0] v;
    for (int i = 0; i < NVEC; i++) busWr(shAddr(i), 32'hB000_0000 | 32'(i), 1'b1);
    doSwap(KEY);
    check("R6 activeBank after swap", {31'b0, activeBank}, 32'd1);
    for (int i = 0; i < NVEC; i++) busWr(shAddr(i), 32'hA000_0000 | 32'(i), 1'b1);
    doFetch(0, v);   check("R2 fetch 0", v, refMem[refSel][0]);
    doFetch(5, v);   check("R2 fetch 5", v, refMem[refSel][5]);
    doFetch(191, v); check("R2 fetch last", v, 32'hB000_00BF);
    busRd(shAddr(5), 1'b1, v);   check("R3 shadow read 5", v, 32'hA000_0005);
    busRd(actAddr(9), 1'b1, v);  check("R6 active window shows swapped bank", v, 32'hB000_0009);
  endtask

  task automatic t_half;
    logic [31:0] v;
    busWr(shAddr(7), 32'hFFFF_1234, 1'b0);
    busWr(shAddr(7) + 1, 32'h0000_BEEF, 1'b0);
    busRd(shAddr(7), 1'b1, v);      check("R4 halves combine", v, 32'hBEEF_1234);
    busRd(shAddr(7) + 1, 1'b0, v);  check("R4 high half read", v, 32'h0000_BEEF);
    busRd(shAddr(7), 1'b0, v);      check("R4 low half read", v, 32'h0000_1234);
    busWr(shAddr(8), 32'h0000_5555, 1'b0);
    busRd(shAddr(8), 1'b1, v);      check("R4 other half kept", v, 32'hA000_5555);
  endtask

  task automatic t_activeReadOnly;
    logic [31:0] v;
    busWr(actAddr(3), 32'hDEAD_BEEF, 1'b1);
    doFetch(3, v);                 check("R5 active write ignored (fetch)", v, 32'hB000_0003);
    busRd(actAddr(3), 1'b1, v);    check("R5 active window read", v, 32'hB000_0003);
    busRd(shAddr(3), 1'b1, v);     check("R5 shadow untouched", v, 32'hA000_0003);
  endtask

  task automatic t_badKey;
    logic [31:0] v;
    doSwap(8'h5A);
    check("R7 bad key no swap", {31'b0, activeBank}, 32'd1);
    doFetch(4, v);                 check("R7 table unchanged", v, 32'hB000_0004);
  endtask

  task automatic t_range;
    logic [31:0] v;
    doFetch(192, v);               check("R2 fetch beyond table", v, 32'h0);
    doFetch(255, v);               check("R2 fetch top index", v, 32'h0);
    busRd(shAddr(200), 1'b1, v);   check("R10 read beyond table", v, 32'h0);
    busWr(shAddr(200), 32'h1111_2222, 1'b1);
    busRd(shAddr(200), 1'b1, v);   check("R10 write beyond table ignored", v, 32'h0);
    busRd(shAddr(8), 1'b1, v);     check("R10 no alias of write", v, refMem[refSel ^ 1'b1][8]);
    busRd(32'h0000_2000, 1'b1, v); check("R10 outside windows", v, 32'h0);
  endtask

  task automatic t_swapCycle;
    logic [31:0] expFetch;
    logic [31:0] v;
    @(negedge clk);
    expFetch = refMem[refSel][10];
    swapReq = 1'b1; swapKey = KEY;
    fetchReq = 1'b1; fetchIdx = 8'd10;
    busReq = 1'b1; busWrite = 1'b1; busWide = 1'b1;
    busAddr = shAddr(11); busWdata = 32'hC0DE_0011;
    modelWrite(shAddr(11), 32'hC0DE_0011, 1'b1);
    refSel = refSel ^ 1'b1;
    @(negedge clk);
    check("R8 fetch in swap cycle uses old bank", fetchVec, expFetch);
    check("R6 activeBank toggled", {31'b0, activeBank}, {31'b0, refSel});
    swapReq = 1'b0; fetchReq = 1'b0; busReq = 1'b0; busWrite = 1'b0;
    doFetch(10, v);  check("R8 next fetch uses new bank", v, 32'hA000_000A);
    doFetch(11, v);  check("R9 swap-cycle write landed in new active", v, 32'hC0DE_0011);
  endtask

  task automatic t_concurrent;
    logic [31:0] expFetch;
    logic [31:0] v;
    @(negedge clk);
    expFetch = refMem[refSel][20];
    fetchReq = 1'b1; fetchIdx = 8'd20;
    busReq = 1'b1; busWrite = 1'b1; busWide = 1'b1;
    busAddr = shAddr(20); busWdata = 32'h7777_0020;
    modelWrite(shAddr(20), 32'h7777_0020, 1'b1);
    @(negedge clk);
    check("R12 fetch unaffected by shadow write", fetchVec, expFetch);
    fetchReq = 1'b0; busReq = 1'b0; busWrite = 1'b0;
    doFetch(20, v);               check("R12 active still intact", v, expFetch);
    busRd(shAddr(20), 1'b1, v);   check("R12 shadow took write", v, 32'h7777_0020);
  endtask

  task automatic t_pingPong;
    logic [31:0] v;
    for (int n = 0; n < 4; n++) begin
      doSwap(KEY);
      check("R11 activeBank alternates", {31'b0, activeBank}, {31'b0, refSel});
      doFetch(0, v);
      check("R11 active table alternates", v, refMem[refSel][0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_fillAndSwap();
    t_half();
    t_activeReadOnly();
    t_badKey();
    t_range();
    t_swapCycle();
    t_concurrent();
    t_pingPong();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule